// File: doc/BRIEF.md
# Tuning Synthesizer Two-Wire Register Interface

This block is a two-wire (I2C) slave that programs the registers of a tuning synthesizer. It samples the bus lines on a fast system clock and recognises its own 7-bit device address, two bits of which come from board straps. One write burst can load three registers, each at its own byte boundary: a 15-bit divider ratio, a 7-bit control word and an 8-bit port word. A read returns one status byte built from a lock flag and a 3-bit converter code.

The first data byte after the address sets the layout of the burst. If its top bit is clear, the burst opens with the divider bytes, followed by the control byte and then the port byte. If its top bit is set, the burst opens with the control byte, followed by the port byte. A register changes only when its closing byte is complete. A START or STOP that arrives partway through a byte drops that byte and keeps every value already loaded.

Top module: `synth_i2c_regs`

## Requirements
- R1: The device address is binary 1100 0 followed by strap_i[1] and strap_i[0], sent MSB first before the R/W bit. The block acknowledges a matching address. For any other address it drives nothing for the rest of that transfer, and its registers stay unchanged.
- R2: In a write, a first data byte with bit 7 = 0 starts the frequency-first order. Its bits 6:0 are N[14:8]. The next byte is N[7:0], then comes the control byte, then the port byte.
- R3: In a write, a first data byte with bit 7 = 1 is the control byte. The next byte is the port byte.
- R4: div_n changes only when the second divider byte is complete. A burst that holds only the first divider byte leaves div_n unchanged.
- R5: Control byte fields: bit 6 drives cp_hi, bits 5:3 drive test_bits, bits 2:1 drive ref_sel (bit 2 goes to ref_sel[1]), and bit 0 drives tune_off. Bit 7 is not stored.
- R6: port_o takes the whole port byte, with bit n of the byte driving port_o[n].
- R7: In an addressed write, every data byte is acknowledged, including bytes after the port byte. Those later bytes change no output.
- R8: A read transfer returns one status byte, MSB first: bit 6 = lock_i, bits 2:0 = adc_i, all other bits 0.
- R9: A START or STOP that arrives partway through a byte discards the partial byte. Registers loaded earlier in the burst keep their values, and a following START begins a new transfer.
- R10: Reset gives div_n = 0, port_o = 0, cp_hi = 0, test_bits = 001, ref_sel = 00, tune_off = 0, and a released SDA.
- R11: The block changes its SDA drive only in the cycle after it detects a falling SCL edge, a START or a STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | When 1, pulls SDA low |
| strap_i | input | 2 | Strap-selected low address bits |
| lock_i | input | 1 | Loop lock flag for the status byte |
| adc_i | input | 3 | Converter code for the status byte |
| div_n | output | 15 | Programmable divider ratio N |
| cp_hi | output | 1 | Charge-pump high-current select |
| test_bits | output | 3 | Test mode bits |
| ref_sel | output | 2 | Reference divider ratio select |
| tune_off | output | 1 | Tuning output disable |
| port_o | output | 8 | Band-switch and port output bits |

## Verification
Random bursts vary four things: the address (matching or not), the strap setting, the top bit of the first byte and the burst length from one to six bytes. Between them they separate the two byte orders, divider-only bursts that must not load N, and trailing bytes that must be acknowledged but ignored. Directed cases decode each control field from a byte with only that field set. Further cases break off a byte with a START and with a STOP to show that committed values survive, and run reads with different lock and converter inputs to check the position of each status bit.

// File: rtl/synth_i2c_pkg.sv
// Shared constants and types for the synthesizer register interface.
// Assumes the fixed part of the device address never changes at run time.
package synth_i2c_pkg;
    localparam int N_W    = 15;
    localparam int PORT_W = 8;
    localparam int ADC_W  = 3;
    localparam int CTL_W  = 7;
    localparam logic [4:0] ADDR_HI = 5'b11000;

    typedef enum logic [2:0] {
        BUS_IDLE, BUS_ADDR, BUS_AACK, BUS_WR, BUS_WACK, BUS_RD, BUS_RACK, BUS_SKIP
    } bus_st_e;

    typedef enum logic [2:0] {
        SEQ_FIRST, SEQ_DB2, SEQ_CB, SEQ_PB, SEQ_DONE
    } seq_e;

    typedef struct packed {
        logic       cp;
        logic [2:0] test;
        logic [1:0] rs;
        logic       os;
    } ctl_t;

    localparam ctl_t CTL_RST = '{cp: 1'b0, test: 3'b001, rs: 2'b00, os: 1'b0};
endpackage

// File: rtl/i2c_line_sync.sv
// Synchronizes SCL and SDA to the system clock and derives edge and
// START/STOP events from the synchronized levels.
// Assumes the bus idles high and SCL is slow against clk.
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);
    localparam int PW = STAGES + 1;

    logic [PW-1:0] scl_pipe;
    logic [PW-1:0] sda_pipe;
    logic scl_now, scl_prev, sda_now, sda_prev;

    // Shift both lines through the synchronizer plus one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
        end else begin
            scl_pipe <= {scl_pipe[PW-2:0], scl_i};
            sda_pipe <= {sda_pipe[PW-2:0], sda_i};
        end
    end

    // Pick the synchronized level and its previous value.
    always_comb begin
        scl_now  = scl_pipe[STAGES-1];
        scl_prev = scl_pipe[STAGES];
        sda_now  = sda_pipe[STAGES-1];
        sda_prev = sda_pipe[STAGES];
    end

    // Decode events: SDA moving while SCL stays high marks START/STOP.
    always_comb begin
        sda_s     = sda_now;
        scl_rise  = scl_now & ~scl_prev;
        scl_fall  = ~scl_now & scl_prev;
        bus_start = scl_now & scl_prev & sda_prev & ~sda_now;
        bus_stop  = scl_now & scl_prev & ~sda_prev & sda_now;
    end
endmodule

// File: rtl/i2c_byte_engine.sv
// Bit-level slave engine: matches the address, receives write bytes,
// acknowledges, and shifts out the status byte on reads.
// Assumes synchronized inputs; changes SDA drive only after SCL falls.
module i2c_byte_engine
    import synth_i2c_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sda_s,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       bus_start,
    input  logic       bus_stop,
    input  logic [1:0] strap,
    input  logic [7:0] status,
    output logic       sda_oe,
    output logic       wr_valid,
    output logic [7:0] wr_byte
);
    localparam logic [3:0] LAST_BIT = 4'd7;
    localparam logic [3:0] ACK_BIT  = 4'd8;

    bus_st_e    st;
    logic [3:0] cnt;
    logic [6:0] sh;
    logic [6:0] tx;
    logic       hit;
    logic       rw;
    logic       mack;

    // Main transfer state machine, advanced by bus events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= BUS_IDLE; cnt <= '0; sh <= '0; tx <= '0;
            sda_oe <= 1'b0; hit <= 1'b0; rw <= 1'b0; mack <= 1'b0;
        end else if (bus_start) begin
            st <= BUS_ADDR; cnt <= '0; sda_oe <= 1'b0;
        end else if (bus_stop) begin
            st <= BUS_IDLE; cnt <= '0; sda_oe <= 1'b0;
        end else begin
            unique case (st)
                BUS_ADDR: begin
                    if (scl_rise) begin
                        sh  <= {sh[5:0], sda_s};
                        cnt <= cnt + 4'd1;
                        if (cnt == LAST_BIT) begin
                            hit <= (sh == {ADDR_HI, strap});
                            rw  <= sda_s;
                        end
                    end else if (scl_fall && cnt == ACK_BIT) begin
                        cnt <= '0;
                        if (hit) begin
                            sda_oe <= 1'b1; st <= BUS_AACK;
                        end else begin
                            st <= BUS_SKIP;
                        end
                    end
                end
                BUS_AACK: begin
                    if (scl_fall) begin
                        cnt <= '0;
                        if (rw) begin
                            tx <= status[6:0]; sda_oe <= ~status[7]; st <= BUS_RD;
                        end else begin
                            sda_oe <= 1'b0; st <= BUS_WR;
                        end
                    end
                end
                BUS_WR: begin
                    if (scl_rise) begin
                        sh  <= {sh[5:0], sda_s};
                        cnt <= cnt + 4'd1;
                    end else if (scl_fall && cnt == ACK_BIT) begin
                        cnt <= '0; sda_oe <= 1'b1; st <= BUS_WACK;
                    end
                end
                BUS_WACK: begin
                    if (scl_fall) begin
                        sda_oe <= 1'b0; st <= BUS_WR;
                    end
                end
                BUS_RD: begin
                    if (scl_rise) begin
                        cnt <= cnt + 4'd1;
                    end else if (scl_fall) begin
                        if (cnt == ACK_BIT) begin
                            cnt <= '0; sda_oe <= 1'b0; st <= BUS_RACK;
                        end else begin
                            sda_oe <= ~tx[6]; tx <= {tx[5:0], 1'b0};
                        end
                    end
                end
                BUS_RACK: begin
                    if (scl_rise) begin
                        mack <= ~sda_s;
                    end else if (scl_fall) begin
                        if (mack) begin
                            tx <= status[6:0]; sda_oe <= ~status[7]; st <= BUS_RD;
                        end else begin
                            st <= BUS_SKIP;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // Flag a complete write byte on the rising edge of its 8th clock.
    always_comb begin
        wr_byte  = {sh, sda_s};
        wr_valid = (st == BUS_WR) && scl_rise && (cnt == LAST_BIT)
                   && !bus_start && !bus_stop;
    end
endmodule

// File: rtl/synth_reg_bank.sv
// Byte-sequence decoder and the divider, control and port registers.
// Assumes one wr_valid pulse per complete byte and seq_clr on START/STOP.
module synth_reg_bank
    import synth_i2c_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seq_clr,
    input  logic              wr_valid,
    input  logic [7:0]        wr_byte,
    output logic [N_W-1:0]    div_n,
    output ctl_t              ctl_q,
    output logic [PORT_W-1:0] port_q
);
    localparam int HI_W = N_W - 8;

    seq_e            seq;
    logic [HI_W-1:0] n_hi;

    // Walk the burst order and commit each register on its closing byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq <= SEQ_FIRST; n_hi <= '0;
            div_n <= '0; ctl_q <= CTL_RST; port_q <= '0;
        end else if (seq_clr) begin
            seq <= SEQ_FIRST;
        end else if (wr_valid) begin
            unique case (seq)
                SEQ_FIRST: begin
                    if (!wr_byte[7]) begin
                        n_hi <= wr_byte[HI_W-1:0]; seq <= SEQ_DB2;
                    end else begin
                        ctl_q <= ctl_t'(wr_byte[CTL_W-1:0]); seq <= SEQ_PB;
                    end
                end
                SEQ_DB2: begin
                    div_n <= {n_hi, wr_byte}; seq <= SEQ_CB;
                end
                SEQ_CB: begin
                    ctl_q <= ctl_t'(wr_byte[CTL_W-1:0]); seq <= SEQ_PB;
                end
                SEQ_PB: begin
                    port_q <= wr_byte[PORT_W-1:0]; seq <= SEQ_DONE;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/synth_i2c_regs.sv
// Top of the synthesizer register interface: line sync, byte engine and
// register bank. Assumes the external pin drives SDA low when sda_oe is 1.
module synth_i2c_regs
    import synth_i2c_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [1:0]        strap_i,
    input  logic              lock_i,
    input  logic [ADC_W-1:0]  adc_i,
    output logic [N_W-1:0]    div_n,
    output logic              cp_hi,
    output logic [2:0]        test_bits,
    output logic [1:0]        ref_sel,
    output logic              tune_off,
    output logic [PORT_W-1:0] port_o
);
    logic       sda_s, scl_rise, scl_fall, bus_start, bus_stop;
    logic       wr_valid;
    logic [7:0] wr_byte;
    logic [7:0] status;
    ctl_t       ctl_q;

    // Assemble the status byte: lock flag in bit 6, converter code low.
    always_comb begin
        status = '0;
        status[6] = lock_i;
        status[ADC_W-1:0] = adc_i;
    end

    // Fan the control word out to its field ports.
    always_comb begin
        cp_hi     = ctl_q.cp;
        test_bits = ctl_q.test;
        ref_sel   = ctl_q.rs;
        tune_off  = ctl_q.os;
    end

    i2c_line_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .bus_start(bus_start), .bus_stop(bus_stop)
    );

    i2c_byte_engine u_eng (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .bus_start(bus_start), .bus_stop(bus_stop),
        .strap(strap_i), .status(status), .sda_oe(sda_oe),
        .wr_valid(wr_valid), .wr_byte(wr_byte)
    );

    synth_reg_bank u_bank (
        .clk(clk), .rst_n(rst_n), .seq_clr(bus_start | bus_stop),
        .wr_valid(wr_valid), .wr_byte(wr_byte), .div_n(div_n),
        .ctl_q(ctl_q), .port_q(port_o)
    );
endmodule

// File: rtl/synth_i2c_chk.sv
// Checker for the register interface, attached to the top by bind.
module synth_i2c_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_valid,
    input logic        scl_fall,
    input logic        bus_start,
    input logic        bus_stop,
    input logic        sda_oe,
    input logic [14:0] div_n,
    input logic [6:0]  ctl_bits,
    input logic [7:0]  port_o
);
    // R10
    reset_values_chk: assert property (@(posedge clk)
        !rst_n |=> (div_n == 15'd0 && port_o == 8'd0 && ctl_bits == 7'b0001000 && !sda_oe));

    // R4
    div_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(div_n) |-> $past(wr_valid));

    // R5
    ctl_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(ctl_bits) |-> $past(wr_valid));

    // R6
    port_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(port_o) |-> $past(wr_valid));

    // R11
    sda_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(sda_oe) |-> $past(scl_fall || bus_start || bus_stop));

    // R9
    abort_no_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_start || bus_stop) |=> $stable(div_n) && $stable(port_o));
endmodule

bind synth_i2c_regs synth_i2c_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .scl_fall(scl_fall),
    .bus_start(bus_start), .bus_stop(bus_stop), .sda_oe(sda_oe),
    .div_n(div_n), .ctl_bits({cp_hi, test_bits, ref_sel, tune_off}),
    .port_o(port_o)
);

// File: tb/sim_synth_i2c_regs.sv
module sim_synth_i2c_regs;
    localparam int QT = 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic [1:0] strap = 2'b00;
    logic lock = 1'b0;
    logic [2:0] adc = 3'd0;
    wire  sda_oe;
    wire  sda_line = sda_m & ~sda_oe;
    logic [14:0] div_n;
    logic cp_hi, tune_off;
    logic [2:0] test_bits;
    logic [1:0] ref_sel;
    logic [7:0] port_o;

    int checks = 0;
    int errs = 0;
    bit done = 0;

    logic [14:0] e_n;
    logic [6:0]  e_ctl;
    logic [7:0]  e_port;
    int          m_seq;
    logic [6:0]  m_hi;
    logic [7:0]  wb [0:7];

    always #2 clk = ~clk;

    synth_i2c_regs u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
        .strap_i(strap), .lock_i(lock), .adc_i(adc), .div_n(div_n), .cp_hi(cp_hi),
        .test_bits(test_bits), .ref_sel(ref_sel), .tune_off(tune_off), .port_o(port_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] status_of(input logic l, input logic [2:0] a);
        return {1'b0, l, 3'b000, a};
    endfunction

    function automatic logic [6:0] dev_addr(input logic [1:0] s);
        return {5'b11000, s};
    endfunction

    // Requirement model of the byte order (R2, R3, R7).
    task automatic model_byte(input logic [7:0] b);
        case (m_seq)
            0: if (!b[7]) begin m_hi = b[6:0]; m_seq = 1; end
               else begin e_ctl = b[6:0]; m_seq = 3; end
            1: begin e_n = {m_hi, b}; m_seq = 2; end
            2: begin e_ctl = b[6:0]; m_seq = 3; end
            3: begin e_port = b; m_seq = 4; end
            default: ;
        endcase
    endtask

    task automatic q(); #(QT); endtask

    task automatic bus_start();
        sda_m = 1'b1; q(); scl = 1'b1; q(); sda_m = 1'b0; q(); scl = 1'b0; q();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; q(); scl = 1'b1; q(); sda_m = 1'b1; q(); q();
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; q(); scl = 1'b1; q(); q(); scl = 1'b0; q();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1'b1; q(); scl = 1'b1; q(); ack = ~sda_line; q(); scl = 1'b0; q();
    endtask

    task automatic recv_byte(output logic [7:0] d);
        sda_m = 1'b1;
        d = '0;
        for (int i = 0; i < 8; i++) begin
            q(); scl = 1'b1; q(); d = {d[6:0], sda_line}; q(); scl = 1'b0; q();
        end
    endtask

    task automatic check_regs(input string tag);
        check({tag, " R2 div_n"}, 32'(div_n), 32'(e_n));
        check({tag, " R3 control"}, 32'({cp_hi, test_bits, ref_sel, tune_off}), 32'(e_ctl));
        check({tag, " R6 ports"}, 32'(port_o), 32'(e_port));
    endtask

    task automatic write_burst(input logic [6:0] a7, input int len);
        logic ack;
        logic hit;
        hit = (a7 == dev_addr(strap));
        bus_start();
        send_byte({a7, 1'b0}, ack);
        check("R1 address ack", 32'(ack), 32'(hit));
        m_seq = 0;
        for (int i = 0; i < len; i++) begin
            send_byte(wb[i], ack);
            check("R7 data ack", 32'(ack), 32'(hit));
            if (hit) model_byte(wb[i]);
        end
        bus_stop();
    endtask

    task automatic read_status();
        logic ack;
        logic [7:0] d;
        bus_start();
        send_byte({dev_addr(strap), 1'b1}, ack);
        check("R8 read address ack", 32'(ack), 32'd1);
        recv_byte(d);
        send_bit(1'b1);
        bus_stop();
        check("R8 status byte", 32'(d), 32'(status_of(lock, adc)));
    endtask

    // Send k bits of a byte then break it off with a START or a STOP.
    task automatic partial_byte(input logic [7:0] b, input int k, input bit use_start);
        for (int i = 7; i > 7 - k; i--) send_bit(b[i]);
        if (use_start) begin
            bus_start();
        end else begin
            bus_stop();
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errs++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errs);
            $finish;
        end
    end

    initial begin
        logic ack;
        void'($urandom(32'd20251));
        e_n = '0; e_ctl = 7'b0001000; e_port = '0; m_seq = 0; m_hi = '0;
        repeat (8) @(posedge clk);
        #1;
        // R10: reset state
        check("R10 div_n", 32'(div_n), 32'd0);
        check("R10 control", 32'({cp_hi, test_bits, ref_sel, tune_off}), 32'h08);
        check("R10 ports", 32'(port_o), 32'd0);
        check("R10 sda", 32'(sda_oe), 32'd0);
        rst_n = 1'b1;
        repeat (4) @(posedge clk);
        #1;

        // R4: divider byte 1 alone leaves N untouched
        strap = 2'b10;
        wb[0] = 8'h55;
        write_burst(dev_addr(strap), 1);
        check("R4 db1 only", 32'(div_n), 32'd0);

        // R2: full frequency-first burst
        wb[0] = 8'h2A; wb[1] = 8'hC3; wb[2] = 8'hC6; wb[3] = 8'hA5;
        write_burst(dev_addr(strap), 4);
        check("R2 N value", 32'(div_n), 32'h2AC3);
        check_regs("directed freq");

        // R5: one field at a time
        wb[0] = 8'hC0; write_burst(dev_addr(strap), 1);
        check("R5 cp_hi", 32'({cp_hi, test_bits, ref_sel, tune_off}), 32'h40);
        wb[0] = 8'hA8; write_burst(dev_addr(strap), 1);
        check("R5 test_bits", 32'(test_bits), 32'd5);
        wb[0] = 8'h84; write_burst(dev_addr(strap), 1);
        check("R5 ref_sel", 32'(ref_sel), 32'd2);
        wb[0] = 8'h81; write_burst(dev_addr(strap), 1);
        check("R5 tune_off", 32'({cp_hi, test_bits, ref_sel, tune_off}), 32'h01);

        // R3 and R7: control-first burst with trailing bytes
        wb[0] = 8'h88; wb[1] = 8'h3C; wb[2] = 8'hFF; wb[3] = 8'h00; wb[4] = 8'h7E;
        write_burst(dev_addr(strap), 5);
        check("R3 ports after control", 32'(port_o), 32'h3C);
        check("R7 trailing ignored", 32'(div_n), 32'h2AC3);

        // R1: wrong strap value is ignored
        wb[0] = 8'h01; wb[1] = 8'h02;
        write_burst(dev_addr(2'b01), 2);
        check("R1 ignored N", 32'(div_n), 32'h2AC3);

        // R9: STOP partway through the control byte after N commits
        bus_start();
        send_byte({dev_addr(strap), 1'b0}, ack);
        send_byte(8'h11, ack); send_byte(8'h22, ack);
        partial_byte(8'hFE, 4, 1'b0);
        e_n = 15'h1122;
        check("R9 N kept after stop", 32'(div_n), 32'h1122);
        check("R9 control kept", 32'({cp_hi, test_bits, ref_sel, tune_off}), 32'h08);

        // R9: START partway through, then a fresh control-first write
        bus_start();
        send_byte({dev_addr(strap), 1'b0}, ack);
        partial_byte(8'hFF, 5, 1'b1);
        send_byte({dev_addr(strap), 1'b0}, ack);
        check("R9 readdress ack", 32'(ack), 32'd1);
        send_byte(8'hB2, ack);
        bus_stop();
        e_ctl = 7'h32;
        check("R9 new control", 32'({cp_hi, test_bits, ref_sel, tune_off}), 32'h32);
        check("R9 ports kept", 32'(port_o), 32'h3C);

        // R8: status reads
        lock = 1'b1; adc = 3'd5; read_status();
        lock = 1'b0; adc = 3'd2; read_status();
        lock = 1'b1; adc = 3'd7; read_status();

        // Random bursts (R1, R2, R3, R7)
        for (int t = 0; t < 40; t++) begin
            logic [6:0] a7;
            int len;
            strap = 2'($urandom_range(0, 3));
            a7 = ($urandom_range(0, 4) == 0) ? dev_addr(2'($urandom_range(0, 3)))
                                             : dev_addr(strap);
            len = $urandom_range(1, 6);
            for (int i = 0; i < 8; i++) wb[i] = 8'($urandom());
            write_burst(a7, len);
            check_regs("random");
            if (t % 8 == 0) begin
                lock = 1'($urandom()); adc = 3'($urandom());
                read_status();
            end
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errs);
        $finish;
    end
endmodule